// File: doc/BRIEF.md
# Exception Return Code Unit

This unit sits beside the program-counter update path of a small microcontroller core. When the core takes an exception, it produces the special code that is loaded into the link register. The code records the mode the core was in and, when that mode was thread mode, which stack was active. From then on it inspects every value written to the program counter.

For each such write it decides one of three outcomes. The write may be an ordinary branch, in which case the unit does nothing. It may be a genuine exception return, in which case the unit emits a one-cycle trigger that starts unstacking and reports the mode and stack to return to. Or it may be an illegal use of the reserved top-of-memory address range, in which case the unit raises exactly one fault pulse. That pulse escalates to a hard fault when the selected fault class is disabled.

A recognised return never branches. The real resume address comes from the frame that the unstacking logic pops, so the value written to the program counter is only a marker.

Top module: `xret_code_unit`

## Requirements
- R1: One cycle after `entry_i` is high with `handler_i` = 1, `lr_code_o` equals 0xFFFFFFF1.
- R2: One cycle after `entry_i` is high with `handler_i` = 0, `lr_code_o` equals 0xFFFFFFF9 when `spsel_i` = 0 and 0xFFFFFFFD when `spsel_i` = 1. Otherwise `lr_code_o` holds its value.
- R3: The kind encodings are 0 = other, 1 = multi-register pop that includes the PC, 2 = single load into the PC, 3 = register branch-exchange, 4 = vector fetch, 5 to 7 = other. A write of 0xFFFFFFF1, 0xFFFFFFF9 or 0xFFFFFFFD in handler mode by kind 1, 2 or 3 gives a one-cycle `ret_trig_o` pulse on the cycle after the strobe. In the same cycle, `ret_handler_o` and `ret_psp_o` become 1/0, 0/0 or 0/1 respectively.
- R4: A PC write whose bits [31:28] are not 0xF raises no pulse and leaves `ret_handler_o` and `ret_psp_o` unchanged.
- R5: A write with bits [31:28] = 0xF made in thread mode, or by kind 0 or 4 to 7, is a plain execute-never address. When bit 0 is 0 it raises `flt_istate_o`; when bit 0 is 1 it raises `flt_mem_o`. It never raises `ret_trig_o`.
- R6: A fault whose class enable is low is reported on `flt_hard_o` instead. `mem_en_i` governs the memory fault; `use_en_i` governs both usage faults.
- R7: A return-path write (handler mode, kind 1 to 3, bits [31:28] = 0xF) whose bits [27:4] are not all ones, or whose bits [3:0] are not 1, 9 or D, raises `flt_iret_o` and no trigger.
- R8: `ret_trig_o`, `flt_mem_o`, `flt_istate_o`, `flt_iret_o` and `flt_hard_o` are registered, mutually exclusive, and high only on the cycle after a cycle with `pcw_valid_i` high.
- R9: Synchronous reset clears every output to 0. `ret_handler_o` and `ret_psp_o` change only together with a `ret_trig_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| handler_i | input | 1 | Current mode: 1 = handler, 0 = thread |
| spsel_i | input | 1 | Stack-select control bit: 1 = process stack |
| entry_i | input | 1 | Exception entry strobe |
| pcw_valid_i | input | 1 | Program-counter write strobe |
| pcw_value_i | input | 32 | Value written to the program counter |
| pcw_kind_i | input | 3 | Kind of instruction or event making the write |
| mem_en_i | input | 1 | Memory-management fault enable |
| use_en_i | input | 1 | Usage fault enable |
| lr_code_o | output | 32 | Link-register code built at exception entry |
| ret_trig_o | output | 1 | One-cycle exception-return trigger |
| ret_handler_o | output | 1 | Return target mode: 1 = handler |
| ret_psp_o | output | 1 | Return stack: 1 = process stack |
| flt_mem_o | output | 1 | Memory-management fault pulse |
| flt_istate_o | output | 1 | Invalid-state usage fault pulse |
| flt_iret_o | output | 1 | Invalid-return usage fault pulse |
| flt_hard_o | output | 1 | Escalated hard fault pulse |

## Verification
Every result is due exactly one clock edge after its stimulus: the link-register code follows the entry strobe, and the pulses and return state follow the PC-write strobe. The driver applies each stimulus on a falling edge and pushes the values predicted from the requirements for the next rising edge. The monitor pops one item per rising edge and compares it 1 ns after that edge. Because idle cycles also push an item, the bench also confirms that pulses last one cycle and that the return state holds.

// File: rtl/xret_pkg.sv
package xret_pkg;

  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_OTHER  = 3'd0,
    K_POP_PC = 3'd1,
    K_LDR_PC = 3'd2,
    K_BX     = 3'd3,
    K_VECTOR = 3'd4
  } pcw_kind_e;

  typedef struct packed {
    logic ret_ok;
    logic bad_ret;
    logic xn_hit;
    logic xn_state;
    logic to_handler;
    logic to_psp;
  } xret_dec_t;

  typedef struct packed {
    logic trig;
    logic mem;
    logic istate;
    logic iret;
    logic hard;
  } xret_pulse_t;

endpackage

// File: rtl/xret_lr_gen.sv
module xret_lr_gen #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            entry,
  input  logic            handler,
  input  logic            spsel,
  output logic [XLEN-1:0] lr_code
);
  localparam int HI_H = XLEN - 4;
  localparam int HI_T = XLEN - 3;

  logic [XLEN-1:0] code_next;

  always_comb begin
    if (handler) code_next = {{HI_H{1'b1}}, 4'b0001};
    else         code_next = {{HI_T{1'b1}}, spsel, 2'b01};
  end

  always_ff @(posedge clk) begin
    if (rst)        lr_code <= '0;
    else if (entry) lr_code <= code_next;
  end
endmodule

// File: rtl/xret_classify.sv
module xret_classify
  import xret_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int TAG_W  = 4,
  parameter int CODE_W = 4
) (
  input  logic              handler,
  input  logic [XLEN-1:0]   value,
  input  logic [KIND_W-1:0] kind,
  output xret_dec_t         dec
);
  localparam int FILL_LO = CODE_W;
  localparam int FILL_HI = XLEN - TAG_W - 1;
  localparam logic [CODE_W-1:0] C_H_MAIN = CODE_W'(4'h1);
  localparam logic [CODE_W-1:0] C_T_MAIN = CODE_W'(4'h9);
  localparam logic [CODE_W-1:0] C_T_PROC = CODE_W'(4'hD);

  logic              cand, fill_ok, known, ret_path;
  logic [CODE_W-1:0] code;

  assign cand    = &value[XLEN-1 -: TAG_W];
  assign fill_ok = &value[FILL_HI:FILL_LO];
  assign code    = value[CODE_W-1:0];
  assign known   = (code == C_H_MAIN) || (code == C_T_MAIN) || (code == C_T_PROC);

  always_comb begin
    unique case (kind)
      K_POP_PC, K_LDR_PC, K_BX: ret_path = handler;
      default:                  ret_path = 1'b0;
    endcase
  end

  always_comb begin
    dec.ret_ok     = cand & ret_path & fill_ok & known;
    dec.bad_ret    = cand & ret_path & ~(fill_ok & known);
    dec.xn_hit     = cand & ~ret_path;
    dec.xn_state   = ~value[0];
    dec.to_handler = (code == C_H_MAIN);
    dec.to_psp     = (code == C_T_PROC);
  end
endmodule

// File: rtl/xret_fault_route.sv
module xret_fault_route
  import xret_pkg::*;
(
  input  logic        strobe,
  input  xret_dec_t   dec,
  input  logic        mem_en,
  input  logic        use_en,
  output xret_pulse_t pul
);
  logic want_mem, want_state, want_iret;

  assign want_mem   = strobe & dec.xn_hit & ~dec.xn_state;
  assign want_state = strobe & dec.xn_hit &  dec.xn_state;
  assign want_iret  = strobe & dec.bad_ret;

  always_comb begin
    pul.trig   = strobe & dec.ret_ok;
    pul.mem    = want_mem   & mem_en;
    pul.istate = want_state & use_en;
    pul.iret   = want_iret  & use_en;
    pul.hard   = (want_mem & ~mem_en) | ((want_state | want_iret) & ~use_en);
  end
endmodule

// File: rtl/xret_code_unit.sv
module xret_code_unit
  import xret_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int TAG_W  = 4,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              handler_i,
  input  logic              spsel_i,
  input  logic              entry_i,
  input  logic              pcw_valid_i,
  input  logic [XLEN-1:0]   pcw_value_i,
  input  logic [KIND_W-1:0] pcw_kind_i,
  input  logic              mem_en_i,
  input  logic              use_en_i,
  output logic [XLEN-1:0]   lr_code_o,
  output logic              ret_trig_o,
  output logic              ret_handler_o,
  output logic              ret_psp_o,
  output logic              flt_mem_o,
  output logic              flt_istate_o,
  output logic              flt_iret_o,
  output logic              flt_hard_o
);
  xret_dec_t   dec;
  xret_pulse_t pul;

  xret_lr_gen #(.XLEN(XLEN)) u_lr (
    .clk(clk), .rst(rst), .entry(entry_i), .handler(handler_i),
    .spsel(spsel_i), .lr_code(lr_code_o)
  );

  xret_classify #(.XLEN(XLEN), .TAG_W(TAG_W), .CODE_W(CODE_W)) u_cls (
    .handler(handler_i), .value(pcw_value_i), .kind(pcw_kind_i), .dec(dec)
  );

  xret_fault_route u_route (
    .strobe(pcw_valid_i), .dec(dec), .mem_en(mem_en_i),
    .use_en(use_en_i), .pul(pul)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_trig_o   <= 1'b0;
      flt_mem_o    <= 1'b0;
      flt_istate_o <= 1'b0;
      flt_iret_o   <= 1'b0;
      flt_hard_o   <= 1'b0;
    end else begin
      ret_trig_o   <= pul.trig;
      flt_mem_o    <= pul.mem;
      flt_istate_o <= pul.istate;
      flt_iret_o   <= pul.iret;
      flt_hard_o   <= pul.hard;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_handler_o <= 1'b0;
      ret_psp_o     <= 1'b0;
    end else if (pul.trig) begin
      ret_handler_o <= dec.to_handler;
      ret_psp_o     <= dec.to_psp;
    end
  end

  assert_handler_code_R1: assert property (@(posedge clk) disable iff (rst)
    entry_i && handler_i |=> lr_code_o == 32'hFFFF_FFF1);

  assert_thread_code_R2: assert property (@(posedge clk) disable iff (rst)
    entry_i && !handler_i |=> lr_code_o == {{(XLEN-3){1'b1}}, $past(spsel_i), 2'b01});

  assert_trig_source_R3: assert property (@(posedge clk) disable iff (rst)
    ret_trig_o |-> $past(pcw_valid_i) && $past(handler_i) && $past(&pcw_value_i[XLEN-1 -: TAG_W]));

  assert_plain_value_R4: assert property (@(posedge clk) disable iff (rst)
    pcw_valid_i && !(&pcw_value_i[XLEN-1 -: TAG_W]) |=> !ret_trig_o && !flt_mem_o && !flt_istate_o && !flt_iret_o && !flt_hard_o);

  assert_thread_no_ret_R5: assert property (@(posedge clk) disable iff (rst)
    pcw_valid_i && !handler_i |=> !ret_trig_o && !flt_iret_o);

  assert_mem_enabled_R6: assert property (@(posedge clk) disable iff (rst)
    flt_mem_o |-> $past(mem_en_i));

  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ret_trig_o, flt_mem_o, flt_istate_o, flt_iret_o, flt_hard_o}));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !pcw_valid_i |=> !ret_trig_o && !flt_mem_o && !flt_istate_o && !flt_iret_o && !flt_hard_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ret_trig_o && !$past(rst) |-> $stable(ret_handler_o) && $stable(ret_psp_o));
endmodule

// File: tb/sim_xret_code_unit.sv
`timescale 1ns/1ps
module sim_xret_code_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        handler_i = 0, spsel_i = 0, entry_i = 0, pcw_valid_i = 0;
  logic [31:0] pcw_value_i = '0;
  logic [2:0]  pcw_kind_i = '0;
  logic        mem_en_i = 1, use_en_i = 1;
  logic [31:0] lr_code_o;
  logic        ret_trig_o, ret_handler_o, ret_psp_o;
  logic        flt_mem_o, flt_istate_o, flt_iret_o, flt_hard_o;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] lr;
    logic [7:0]  flags;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_lr = '0;
  logic        m_h = 0, m_p = 0;

  always #2.5 clk = ~clk;

  xret_code_unit u0 (
    .clk(clk), .rst(rst), .handler_i(handler_i), .spsel_i(spsel_i),
    .entry_i(entry_i), .pcw_valid_i(pcw_valid_i), .pcw_value_i(pcw_value_i),
    .pcw_kind_i(pcw_kind_i), .mem_en_i(mem_en_i), .use_en_i(use_en_i),
    .lr_code_o(lr_code_o), .ret_trig_o(ret_trig_o), .ret_handler_o(ret_handler_o),
    .ret_psp_o(ret_psp_o), .flt_mem_o(flt_mem_o), .flt_istate_o(flt_istate_o),
    .flt_iret_o(flt_iret_o), .flt_hard_o(flt_hard_o)
  );

  function automatic logic [7:0] act_flags();
    return {1'b0, ret_trig_o, ret_handler_o, ret_psp_o,
            flt_mem_o, flt_istate_o, flt_iret_o, flt_hard_o};
  endfunction

  // Driver: applies one cycle of stimulus and predicts the result from R1..R9.
  task automatic step(input logic h, sp, en, pv, input logic [31:0] v,
                      input logic [2:0] k, input logic me, ue, input string tag);
    logic trig, mem, ist, iret, hard, cand, rpath;
    exp_t e;
    @(negedge clk);
    handler_i = h; spsel_i = sp; entry_i = en; pcw_valid_i = pv;
    pcw_value_i = v; pcw_kind_i = k; mem_en_i = me; use_en_i = ue;
    {trig, mem, ist, iret, hard} = '0;
    if (en) m_lr = h ? 32'hFFFF_FFF1 : {29'h1FFF_FFFF, sp, 2'b01};
    cand  = (v[31:28] == 4'hF);
    rpath = h && (k == 3'd1 || k == 3'd2 || k == 3'd3);
    if (pv && cand) begin
      if (rpath) begin
        if (v == 32'hFFFF_FFF1 || v == 32'hFFFF_FFF9 || v == 32'hFFFF_FFFD) begin
          trig = 1; m_h = (v[3:0] == 4'h1); m_p = (v[3:0] == 4'hD);
        end else if (ue) iret = 1;
        else hard = 1;
      end else if (!v[0]) begin
        if (ue) ist = 1; else hard = 1;
      end else begin
        if (me) mem = 1; else hard = 1;
      end
    end
    e.lr = m_lr;
    e.flags = {1'b0, trig, m_h, m_p, mem, ist, iret, hard};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 32'h0, 3'd0, 1, 1, tag);
  endtask

  // Monitor: every result is due one edge after its stimulus.
  always @(posedge clk) begin
    if (mon_on) begin
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (lr_code_o !== e.lr || act_flags() !== e.flags) begin
          fails++;
          $display("FAIL %s: actual lr=%h flags=%b expected lr=%h flags=%b",
                   e.tag, lr_code_o, act_flags(), e.lr, e.flags);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog R8: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (lr_code_o !== 32'h0 || act_flags() !== 8'h0) begin
      fails++;
      $display("FAIL reset R9: actual lr=%h flags=%b expected lr=0 flags=0",
               lr_code_o, act_flags());
    end
    mon_on = 1;
    // R1 / R2 entry codes
    step(1, 0, 1, 0, 32'h0, 0, 1, 1, "R1 handler entry");
    step(0, 0, 1, 0, 32'h0, 0, 1, 1, "R2 thread main entry");
    step(0, 1, 1, 0, 32'h0, 0, 1, 1, "R2 thread process entry");
    idle("R2 code holds");
    // R3 valid returns through each kind
    step(1, 0, 0, 1, 32'hFFFF_FFFD, 3'd3, 1, 1, "R3 bx to thread process");
    idle("R8 trig single cycle");
    step(1, 0, 0, 1, 32'hFFFF_FFF9, 3'd1, 1, 1, "R3 pop to thread main");
    step(1, 0, 0, 1, 32'hFFFF_FFF1, 3'd2, 1, 1, "R3 ldr to handler main");
    step(1, 1, 1, 1, 32'hFFFF_FFFD, 3'd3, 1, 1, "R3 R1 return with entry");
    // R4 plain values
    step(1, 0, 0, 1, 32'h0800_1235, 3'd3, 1, 1, "R4 plain bx");
    step(1, 0, 0, 1, 32'hEFFF_FFF9, 3'd1, 1, 1, "R4 nibble E");
    step(0, 0, 0, 1, 32'h2000_0000, 3'd0, 1, 1, "R4 plain thread");
    // R5 execute-never
    step(0, 0, 0, 1, 32'hFFFF_FFF9, 3'd3, 1, 1, "R5 thread bx mem");
    step(0, 0, 0, 1, 32'hF000_0000, 3'd2, 1, 1, "R5 thread ldr istate");
    step(1, 0, 0, 1, 32'hFFFF_FFF1, 3'd4, 1, 1, "R5 vector fetch mem");
    step(1, 0, 0, 1, 32'hFFFF_FFF8, 3'd0, 1, 1, "R5 other kind istate");
    step(1, 0, 0, 1, 32'hFFFF_FFF9, 3'd6, 1, 1, "R5 kind 6 mem");
    // R6 escalation
    step(0, 0, 0, 1, 32'hFFFF_FFFD, 3'd3, 0, 1, "R6 mem disabled hard");
    step(0, 0, 0, 1, 32'hF000_0010, 3'd1, 1, 0, "R6 istate disabled hard");
    step(0, 0, 0, 1, 32'hF000_0011, 3'd1, 1, 0, "R6 mem enabled use off");
    step(1, 0, 0, 1, 32'hFFFF_FFF5, 3'd3, 1, 0, "R6 iret disabled hard");
    // R7 invalid returns
    step(1, 0, 0, 1, 32'hFFFF_FFF5, 3'd3, 1, 1, "R7 bad low code");
    step(1, 0, 0, 1, 32'hFFFF_0FF1, 3'd1, 1, 1, "R7 bad fill");
    step(1, 0, 0, 1, 32'hF000_0009, 3'd2, 0, 1, "R7 bad fill mem off");
    step(1, 0, 0, 1, 32'hFFFF_FFF0, 3'd3, 1, 1, "R7 code zero");
    // R8 / R9 quiet and hold
    step(1, 0, 0, 0, 32'hFFFF_FFF1, 3'd3, 1, 1, "R8 no strobe no pulse");
    step(1, 0, 0, 1, 32'hFFFF_FFF9, 3'd3, 1, 1, "R3 back to thread main");
    step(1, 1, 0, 1, 32'hFFFF_FFFD, 3'd2, 1, 1, "R3 to process");
    step(0, 0, 0, 1, 32'hFFFF_FFF1, 3'd1, 1, 1, "R9 fault keeps state");
    idle("R9 idle hold");
    idle("R9 idle hold 2");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL drain R8: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule